// File: doc/BRIEF.md
# AC-link Input Frame Formatter

This block builds the serial frame that a codec returns to its controller on an AC-link-style interface. On every frame start it gathers the current configuration, the pending register read response and the pending stereo ADC sample. It then assembles a 256-bit frame from these and shifts it out one bit per bit clock, most significant bit first.

The frame starts with a 16-bit tag slot. Twelve 20-bit slots follow it. Slot 1 carries the status address and the slot-request field. Slot 2 carries the register read data. The stereo sample is placed on one of four selectable slot pairs. All other slots are sent as zero with their tags cleared.

A read response or a sample presented to the block is held until the next frame boundary. It is sent in exactly one frame.

Top module: `ac_in_frame_fmt`

## Requirements
- R1: While `rst` is high, and at the first clock edge after it, `sdata` is 0. A frame sent after reset with no read and no sample carries no read tags and no PCM tags.
- R2: The clock edge that sees `sync` change from 0 to 1 drives frame bit 255 on `sdata`. Each of the next 255 edges drives the next lower bit. The frame is slot 0 in bits 255..240, then slot k (k = 1..12) in bits 259-20k down to 240-20k.
- R3: Slot 0 bit 15 (frame bit 255) equals `codec_ready` at the frame start edge. Slot 0 bits 2..0 are always 0.
- R4: The tags for slot 1 and slot 2 (slot 0 bits 14 and 13) are both 1 in the first frame that starts after a `rd_req` pulse, and both 0 in every other frame.
- R5: In a frame with read tags set, slot 1 bits 18..12 carry `rd_addr`. Slot 1 bits 19 and 1..0 are always 0, and bits 18..12 are 0 when the read tags are clear.
- R6: The slot-request field is slot 1 bits 11..2, where slot s (3..12) maps to bit 14-s. The bits of the two slots that carry the ADC pair are 1 exactly when `vra_en`, `adc_ready` and `rate_non48` are 1 and `need_sample` is 0. All other slot-request bits are 0. This holds whether or not the read tags are set.
- R7: Slot 2 bits 19..4 carry `rd_data`, and bits 3..0 are 0. The whole slot is 0 when its tag is clear.
- R8: `pair_sel` places the left sample in the first slot and the right sample in the second slot of the pair: 0 selects 3&4, 1 selects 6&9, 2 selects 7&8, and 3 selects 10&11.
- R9: The tags of the selected pair (slot 0 bit 15-s for slot s) are 1 only in the first frame that starts after an `adc_strobe` pulse. Slot 5, the unselected PCM slots, and the selected pair when its tags are clear are all-zero, with their tags clear.
- R10: Inputs are sampled only at the frame start edge. Changes to the configuration, the samples or the read data during a frame do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| sync | input | 1 | Frame sync; a rising edge starts a frame |
| codec_ready | input | 1 | Codec ready flag for slot 0 bit 15 |
| rd_req | input | 1 | One-cycle pulse: a register read response is available |
| rd_addr | input | 7 | Register index of the read response |
| rd_data | input | 16 | Register read data |
| adc_strobe | input | 1 | One-cycle pulse: a new stereo sample is available |
| adc_left | input | 20 | Left ADC sample |
| adc_right | input | 20 | Right ADC sample |
| vra_en | input | 1 | Variable-rate mode enable |
| adc_ready | input | 1 | ADC powered up and ready |
| rate_non48 | input | 1 | ADC rate differs from 48 kHz |
| need_sample | input | 1 | Codec needs a sample in this frame |
| pair_sel | input | 2 | Slot pair code for the ADC pair |
| sdata | output | 1 | Serial frame data, MSB first |

## Verification
A pending flag that is never cleared would show up as read or PCM tags repeated in the frame after a response, visible within 256 bit clocks. A flag that is cleared too early would show up as a missing tag in the very frame that should carry it. A wrong routing decode or slot offset would place a sample or a request bit at a wrong bit position of the next frame. A skew in the shifter would shift every field by one bit, and the first bit after the sync edge would already be wrong.

// File: rtl/ac_in_fmt_pkg.sv
package ac_in_fmt_pkg;

    parameter int unsigned TAG_W     = 16;
    parameter int unsigned SLOT_W    = 20;
    parameter int unsigned NUM_SLOTS = 12;
    parameter int unsigned ADDR_W    = 7;
    parameter int unsigned DATA_W    = 16;
    parameter int unsigned SAMPLE_W  = 20;
    parameter int unsigned FRAME_W   = TAG_W + NUM_SLOTS * SLOT_W;

    // Bit positions inside slot 1 and slot 2
    parameter int unsigned ADDR_LSB  = 12;
    parameter int unsigned DATA_LSB  = 4;
    parameter int unsigned REQ_TOP   = 14;

    typedef enum logic [1:0] {
        PAIR_3_4   = 2'd0,
        PAIR_6_9   = 2'd1,
        PAIR_7_8   = 2'd2,
        PAIR_10_11 = 2'd3
    } pair_e;

    typedef struct packed {
        logic  vra_en;
        logic  adc_ready;
        logic  rate_non48;
        logic  need_sample;
        pair_e pair;
    } route_cfg_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } rd_resp_t;

    typedef struct packed {
        logic                valid;
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } stereo_t;

    function automatic int unsigned left_slot(pair_e p);
        case (p)
            PAIR_3_4: return 3;
            PAIR_6_9: return 6;
            PAIR_7_8: return 7;
            default:  return 10;
        endcase
    endfunction

    function automatic int unsigned right_slot(pair_e p);
        case (p)
            PAIR_3_4: return 4;
            PAIR_6_9: return 9;
            PAIR_7_8: return 8;
            default:  return 11;
        endcase
    endfunction

    // LSB position of data slot k (1..NUM_SLOTS) inside the frame
    function automatic int unsigned slot_lsb(int unsigned k);
        return FRAME_W - TAG_W - k * SLOT_W;
    endfunction

endpackage

// File: rtl/ac_status_slots.sv
module ac_status_slots
    import ac_in_fmt_pkg::*;
(
    input  rd_resp_t          rd,
    input  route_cfg_t        cfg,
    output logic              rd_tag,
    output logic [SLOT_W-1:0] slot1,
    output logic [SLOT_W-1:0] slot2
);
    logic req_ok;

    assign req_ok = cfg.vra_en && cfg.adc_ready && cfg.rate_non48 && !cfg.need_sample;
    assign rd_tag = rd.valid;

    always_comb begin
        slot1 = '0;
        slot2 = '0;
        if (rd.valid) begin
            slot1[ADDR_LSB +: ADDR_W] = rd.addr;
            slot2[DATA_LSB +: DATA_W] = rd.data;
        end
        for (int unsigned s = 3; s <= NUM_SLOTS; s++) begin
            if (req_ok && (s == left_slot(cfg.pair) || s == right_slot(cfg.pair)))
                slot1[REQ_TOP - s] = 1'b1;
        end
    end
endmodule

// File: rtl/ac_pcm_router.sv
module ac_pcm_router
    import ac_in_fmt_pkg::*;
(
    input  stereo_t                           smp,
    input  pair_e                             pair,
    output logic [NUM_SLOTS-1:0]              tags,
    output logic [NUM_SLOTS-1:0][SLOT_W-1:0]  data
);
    genvar g;
    generate
        for (g = 0; g < NUM_SLOTS; g++) begin : g_slot
            localparam int unsigned SNUM = g + 1;
            if (SNUM < 3) begin : g_ctrl
                assign tags[g] = 1'b0;
                assign data[g] = '0;
            end else begin : g_pcm
                logic is_l, is_r;
                assign is_l    = (SNUM == left_slot(pair));
                assign is_r    = (SNUM == right_slot(pair));
                assign tags[g] = smp.valid && (is_l || is_r);
                assign data[g] = !smp.valid ? '0 :
                                 is_l       ? SLOT_W'(smp.left) :
                                 is_r       ? SLOT_W'(smp.right) : '0;
            end
        end
    endgenerate
endmodule

// File: rtl/ac_frame_shifter.sv
module ac_frame_shifter
    import ac_in_fmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    output logic               sdata
);
    logic [FRAME_W-2:0] rest_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rest_q <= '0;
            sdata  <= 1'b0;
        end else if (load) begin
            sdata  <= frame[FRAME_W-1];
            rest_q <= frame[FRAME_W-2:0];
        end else begin
            sdata  <= rest_q[FRAME_W-2];
            rest_q <= {rest_q[FRAME_W-3:0], 1'b0};
        end
    end
endmodule

// File: rtl/ac_in_frame_fmt.sv
module ac_in_frame_fmt
    import ac_in_fmt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sync,
    input  logic                codec_ready,
    input  logic                rd_req,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [DATA_W-1:0]   rd_data,
    input  logic                adc_strobe,
    input  logic [SAMPLE_W-1:0] adc_left,
    input  logic [SAMPLE_W-1:0] adc_right,
    input  logic                vra_en,
    input  logic                adc_ready,
    input  logic                rate_non48,
    input  logic                need_sample,
    input  logic [1:0]          pair_sel,
    output logic                sdata
);
    logic       sync_d;
    logic       frame_load;
    rd_resp_t   rd_q;
    stereo_t    smp_q;
    route_cfg_t cfg;

    logic                             rd_tag;
    logic [SLOT_W-1:0]                slot1, slot2;
    logic [NUM_SLOTS-1:0]             pcm_tags;
    logic [NUM_SLOTS-1:0][SLOT_W-1:0] pcm_data;
    logic [FRAME_W-1:0]               frame_w;

    assign frame_load = sync && !sync_d;
    assign cfg = '{vra_en: vra_en, adc_ready: adc_ready, rate_non48: rate_non48,
                   need_sample: need_sample, pair: pair_e'(pair_sel)};

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_d <= 1'b0;
            rd_q   <= '0;
            smp_q  <= '0;
        end else begin
            sync_d <= sync;
            if (frame_load) begin
                rd_q.valid  <= 1'b0;
                smp_q.valid <= 1'b0;
            end
            if (rd_req)
                rd_q <= '{valid: 1'b1, addr: rd_addr, data: rd_data};
            if (adc_strobe)
                smp_q <= '{valid: 1'b1, left: adc_left, right: adc_right};
        end
    end

    ac_status_slots u_status (
        .rd    (rd_q),
        .cfg   (cfg),
        .rd_tag(rd_tag),
        .slot1 (slot1),
        .slot2 (slot2)
    );

    ac_pcm_router u_router (
        .smp (smp_q),
        .pair(cfg.pair),
        .tags(pcm_tags),
        .data(pcm_data)
    );

    always_comb begin
        frame_w = '0;
        frame_w[FRAME_W-1] = codec_ready;
        frame_w[FRAME_W-2] = rd_tag;
        frame_w[FRAME_W-3] = rd_tag;
        frame_w[slot_lsb(1) +: SLOT_W] = slot1;
        frame_w[slot_lsb(2) +: SLOT_W] = slot2;
        for (int unsigned k = 3; k <= NUM_SLOTS; k++) begin
            frame_w[FRAME_W-1-k]           = pcm_tags[k-1];
            frame_w[slot_lsb(k) +: SLOT_W] = pcm_data[k-1];
        end
    end

    ac_frame_shifter u_shift (
        .clk  (clk),
        .rst  (rst),
        .load (frame_load),
        .frame(frame_w),
        .sdata(sdata)
    );
endmodule

// File: rtl/ac_in_frame_chk.sv
module ac_in_frame_chk (
    input logic        clk,
    input logic        rst,
    input logic        load,
    input logic        first_bit,
    input logic        tag_addr,
    input logic        tag_data,
    input logic [19:0] slot2,
    input logic [9:0]  req_field,
    input logic [9:0]  pcm_tags,
    input logic [19:0] slot5,
    input logic        vra_en,
    input logic        adc_ready,
    input logic        rd_pend,
    input logic        rd_req,
    input logic        sdata
);
    AST_FIRST_BIT_OUT: assert property (@(posedge clk) disable iff (rst)
        load |=> (sdata == $past(first_bit)));                                   // R2
    AST_READ_TAGS_PAIRED: assert property (@(posedge clk) disable iff (rst)
        load |-> (tag_addr == tag_data));                                         // R4
    AST_READ_TAG_FROM_PEND: assert property (@(posedge clk) disable iff (rst)
        load |-> (tag_addr == rd_pend));                                          // R4
    AST_READ_ONE_FRAME: assert property (@(posedge clk) disable iff (rst)
        (load && !rd_req) |=> !rd_pend);                                          // R4
    AST_REQ_NEEDS_VRA: assert property (@(posedge clk) disable iff (rst)
        (load && !(vra_en && adc_ready)) |-> (req_field == 10'd0));               // R6
    AST_SLOT2_STUFFED: assert property (@(posedge clk) disable iff (rst)
        (load && !tag_data) |-> (slot2 == 20'd0));                                // R7
    AST_PAIR_TAGS: assert property (@(posedge clk) disable iff (rst)
        load |-> ($countones(pcm_tags) == 0 || $countones(pcm_tags) == 2));       // R8
    AST_SLOT5_ZERO: assert property (@(posedge clk) disable iff (rst)
        load |-> (slot5 == 20'd0 && pcm_tags[7] == 1'b0));                        // R9
endmodule

bind ac_in_frame_fmt ac_in_frame_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .load     (frame_load),
    .first_bit(frame_w[255]),
    .tag_addr (frame_w[254]),
    .tag_data (frame_w[253]),
    .slot2    (frame_w[219:200]),
    .req_field(frame_w[231:222]),
    .pcm_tags (frame_w[252:243]),
    .slot5    (frame_w[159:140]),
    .vra_en   (vra_en),
    .adc_ready(adc_ready),
    .rd_pend  (rd_q.valid),
    .rd_req   (rd_req),
    .sdata    (sdata)
);

// File: tb/ac_in_frame_fmt_bench.sv
module ac_in_frame_fmt_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sync = 1'b0;
    logic        codec_ready = 1'b0;
    logic        rd_req = 1'b0;
    logic [6:0]  rd_addr = '0;
    logic [15:0] rd_data = '0;
    logic        adc_strobe = 1'b0;
    logic [19:0] adc_left = '0;
    logic [19:0] adc_right = '0;
    logic        vra_en = 1'b0;
    logic        adc_ready = 1'b0;
    logic        rate_non48 = 1'b0;
    logic        need_sample = 1'b0;
    logic [1:0]  pair_sel = '0;
    logic        sdata;

    int checks = 0;
    int errors = 0;
    logic [255:0] got;

    always #5 clk = ~clk;

    ac_in_frame_fmt u_ac_in_frame_fmt (
        .clk(clk), .rst(rst), .sync(sync), .codec_ready(codec_ready),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
        .adc_strobe(adc_strobe), .adc_left(adc_left), .adc_right(adc_right),
        .vra_en(vra_en), .adc_ready(adc_ready), .rate_non48(rate_non48),
        .need_sample(need_sample), .pair_sel(pair_sel), .sdata(sdata)
    );

    function automatic int lsb_of(int k);
        return 240 - 20 * k;
    endfunction

    function automatic logic [255:0] exp_frame(
        input logic cr, input logic rdv, input logic [6:0] a, input logic [15:0] d,
        input logic vra, input logic rdy, input logic n48, input logic need,
        input logic [1:0] pr, input logic sv, input logic [19:0] l, input logic [19:0] r);
        logic [255:0] f;
        int ls, rs;
        f = '0;
        ls = (pr == 2'd0) ? 3 : (pr == 2'd1) ? 6 : (pr == 2'd2) ? 7 : 10;
        rs = (pr == 2'd0) ? 4 : (pr == 2'd1) ? 9 : (pr == 2'd2) ? 8 : 11;
        f[255] = cr;
        if (rdv) begin
            f[254] = 1'b1;
            f[253] = 1'b1;
            f[lsb_of(1) + 12 +: 7] = a;
            f[lsb_of(2) + 4 +: 16] = d;
        end
        if (vra && rdy && n48 && !need) begin
            f[lsb_of(1) + 14 - ls] = 1'b1;
            f[lsb_of(1) + 14 - rs] = 1'b1;
        end
        if (sv) begin
            f[255 - ls] = 1'b1;
            f[255 - rs] = 1'b1;
            f[lsb_of(ls) +: 20] = l;
            f[lsb_of(rs) +: 20] = r;
        end
        return f;
    endfunction

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Starts a frame and captures its 256 bits; optionally alters inputs mid-frame.
    task automatic grab_frame(input bit disturb);
        @(negedge clk);
        sync = 1'b1;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            got[255 - i] = sdata;
            if (i == 0) sync = 1'b0;
            if (disturb && i == 100) begin
                pair_sel    = pair_sel + 2'd1;
                vra_en      = ~vra_en;
                need_sample = ~need_sample;
                adc_left    = ~adc_left;
                rd_data     = ~rd_data;
                codec_ready = ~codec_ready;
            end
        end
    endtask

    task automatic post_read(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        rd_addr = a; rd_data = d; rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic post_sample(input logic [19:0] l, input logic [19:0] r);
        @(negedge clk);
        adc_left = l; adc_right = r; adc_strobe = 1'b1;
        @(negedge clk);
        adc_strobe = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [255:0] e;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 sdata in reset", {255'd0, sdata}, 256'd0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 sdata after reset", {255'd0, sdata}, 256'd0);
        grab_frame(1'b0);
        check("R1 idle frame", got, 256'd0);

        // R2/R3: codec ready flag is the first bit
        codec_ready = 1'b1;
        grab_frame(1'b0);
        check("R3 ready flag frame", got, exp_frame(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        check("R2 first bit", {255'd0, got[255]}, 256'd1);

        // R8/R9: every pair, with and without a sample
        for (int p = 0; p < 4; p++) begin
            for (int s = 0; s < 2; s++) begin
                logic [19:0] l, r;
                l = 20'hA5000 + 20'(p * 20'h01111) + 20'(s);
                r = 20'h3C00F ^ 20'(p * 20'h00F31);
                pair_sel = 2'(p);
                if (s == 1) post_sample(l, r);
                grab_frame(1'b0);
                e = exp_frame(1, 0, 0, 0, 0, 0, 0, 0, 2'(p), s[0], l, r);
                check(s == 1 ? "R8 pair routing" : "R9 untagged pair zero", got, e);
                check("R9 slot5 zero", {236'd0, got[159:140]}, 256'd0);
            end
        end

        // R9: sample tags last one frame only
        pair_sel = 2'd2;
        post_sample(20'h12345, 20'h6789A);
        grab_frame(1'b0);
        grab_frame(1'b0);
        check("R9 sample cleared next frame", got, exp_frame(1, 0, 0, 0, 0, 0, 0, 0, 2, 0, 0, 0));

        // R6: slot-request rule, all combinations, with and without a read
        for (int c = 0; c < 16; c++) begin
            vra_en = c[0]; adc_ready = c[1]; rate_non48 = c[2]; need_sample = c[3];
            pair_sel = 2'(c);
            if (c[0]) post_read(7'(c * 5 + 2), 16'hBEEF ^ 16'(c));
            grab_frame(1'b0);
            e = exp_frame(1, c[0], 7'(c * 5 + 2), 16'hBEEF ^ 16'(c), c[0], c[1], c[2], c[3],
                          2'(c), 0, 0, 0);
            check("R6 slot request", got, e);
        end
        vra_en = 0; adc_ready = 0; rate_non48 = 0; need_sample = 0;

        // R4/R5/R7: read tags in exactly one frame
        pair_sel = 2'd0;
        post_read(7'h7F, 16'hFFFF);
        grab_frame(1'b0);
        check("R5 R7 read frame", got, exp_frame(1, 1, 7'h7F, 16'hFFFF, 0, 0, 0, 0, 0, 0, 0, 0));
        check("R7 reserved bits", {252'd0, got[203:200]}, 256'd0);
        check("R5 reserved bits", {253'd0, got[239], got[221:220]}, 256'd0);
        grab_frame(1'b0);
        check("R4 read tags cleared", got, exp_frame(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));

        // R10: inputs changing mid-frame do not affect the running frame
        vra_en = 1; adc_ready = 1; rate_non48 = 1; need_sample = 0; pair_sel = 2'd1;
        post_read(7'h26, 16'h1357);
        post_sample(20'hFEDCB, 20'h01234);
        grab_frame(1'b1);
        check("R10 frame unaffected", got,
              exp_frame(1, 1, 7'h26, 16'h1357, 1, 1, 1, 0, 1, 1, 20'hFEDCB, 20'h01234));
        grab_frame(1'b0);
        check("R10 new settings next frame", got,
              exp_frame(0, 0, 0, 0, 0, 1, 1, 1, 2, 0, 0, 0));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule